// File: doc/BRIEF.md
# Configurable Single-Bit Register with Emulated Set

This block turns a generic one-bit flop request into a single fixed storage cell. The storage cell is limited. It captures on a rising edge, it has an active-high clock enable, a synchronous clear, and a synchronous load of an alternate data value. Its asynchronous clear is active low, and it always powers up holding zero.

A small adapter sits in front of the cell. It meets the other requests by inverting signals. A falling-edge request inverts the clock. An active-low enable or reset inverts that pin. An asynchronous set inverts the data going in and the value coming out, so the cell's clear shows as a one at the output. When set emulation is active, the synchronous clear is folded into the synchronous load, so that a clear still shows zero at the output.

Some requests cannot be built, because the cell can only power up to zero. These are an initial value of one with no reset or with a clear, and an initial value of zero with a set. For these requests the block drives a constant configuration-error flag.

Top module: `flop_map_cell`

## Requirements
- R1: Before any clock edge or reset, q_o equals the power-up value of the configuration: 1 when RST_KIND is set, otherwise 0.
- R2: The register captures only on the selected clock edge (rising when CLK_FALL=0, falling when CLK_FALL=1), and only while enable is at its active level (high when EN_ACT_LOW=0, low when EN_ACT_LOW=1).
- R3: On a capture, the next q_o is 0 if sclr_i=1, else sdata_i if sload_i=1, else d_i.
- R4: While enable is inactive, q_o holds its value whatever d_i, sdata_i, sload_i and sclr_i do.
- R5: With RST_KIND clear, q_o becomes 0 as soon as arst_i reaches its active level (high when RST_ACT_LOW=0, low when RST_ACT_LOW=1). No clock edge is needed, and q_o stays 0 while the reset is held, overriding any capture.
- R6: With RST_KIND set, q_o becomes 1 as soon as the reset is active, and it stays 1 while the reset is held.
- R7: With RST_KIND none, arst_i has no effect on q_o.
- R8: With RST_KIND set, a capture with sclr_i=1 still gives q_o=0, and sload_i still loads sdata_i without inversion.
- R9: cfg_err_o is 1 exactly when INIT_VAL=1 with RST_KIND none or clear, or INIT_VAL=0 with RST_KIND set; otherwise it is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; the active edge is chosen by CLK_FALL |
| arst_i | input | 1 | Asynchronous reset request; its active level is chosen by RST_ACT_LOW |
| en_i | input | 1 | Clock enable; its active level is chosen by EN_ACT_LOW |
| d_i | input | 1 | Normal data input |
| sdata_i | input | 1 | Alternate data, taken when sload_i is high |
| sload_i | input | 1 | Synchronous load select |
| sclr_i | input | 1 | Synchronous clear to zero |
| q_o | output | 1 | Stored value |
| cfg_err_o | output | 1 | Constant flag: the requested power-up value cannot be built |

## Verification
Two events can meet in one cycle. The reset can be active at the same clock edge where an enabled capture of new data would happen, and synchronous clear and synchronous load can both be high at one capture. The bench holds the reset active while enable is on and the data differs from the reset value. It expects the reset value to win for the clear and set kinds, and the capture to win for the none kind. It also raises sclr_i and sload_i together and expects zero at the output in every reset kind, including the inverted set emulation. All 24 legal combinations of clock edge, reset kind, reset polarity and enable polarity run side by side against one behavioural expectation. Each combination is sampled after the rising edge and again after the falling edge.

// File: rtl/flop_map_pkg.sv
package flop_map_pkg;
  typedef enum logic [1:0] {
    RK_NONE  = 2'd0,
    RK_CLEAR = 2'd1,
    RK_SET   = 2'd2
  } rst_kind_e;
endpackage

// File: rtl/flop_store_core.sv
// Fixed storage cell: rising edge, active-high enable, powers up to zero.
module flop_store_core (
  input  logic clk_i,
  input  logic aclr_ni,
  input  logic ena_i,
  input  logic sclr_i,
  input  logic sload_i,
  input  logic sdata_i,
  input  logic d_i,
  output logic q_o
);
  logic q_r = 1'b0;
  logic nxt;

  always_comb begin
    if (sclr_i)       nxt = 1'b0;
    else if (sload_i) nxt = sdata_i;
    else              nxt = d_i;
  end

  always_ff @(posedge clk_i or negedge aclr_ni) begin
    if (!aclr_ni)   q_r <= 1'b0;
    else if (ena_i) q_r <= nxt;
  end

  assign q_o = q_r;

  AST_HOLD_NO_EN: assert property (@(posedge clk_i) disable iff (!aclr_ni)
    !ena_i |=> $stable(q_r)); // R4
  AST_SCLR_ZERO: assert property (@(posedge clk_i) disable iff (!aclr_ni)
    (ena_i && sclr_i) |=> (q_r == 1'b0)); // R3
  AST_SLOAD_TAKE: assert property (@(posedge clk_i) disable iff (!aclr_ni)
    (ena_i && !sclr_i && sload_i) |=> (q_r == $past(sdata_i))); // R3
  AST_ACLR_ZERO: assert property (@(posedge clk_i) disable iff (aclr_ni)
    1'b1 |-> (q_r == 1'b0)); // R5
endmodule

// File: rtl/flop_pin_adapt.sv
// Maps the requested polarities and reset kind onto the core pins.
module flop_pin_adapt
  import flop_map_pkg::*;
#(
  parameter bit        CLK_FALL    = 1'b0,
  parameter rst_kind_e RST_KIND    = RK_CLEAR,
  parameter bit        RST_ACT_LOW = 1'b1,
  parameter bit        EN_ACT_LOW  = 1'b0
) (
  input  logic clk_i,
  input  logic arst_i,
  input  logic en_i,
  input  logic d_i,
  input  logic sdata_i,
  input  logic sload_i,
  input  logic sclr_i,
  output logic core_clk_o,
  output logic core_aclr_no,
  output logic core_ena_o,
  output logic core_d_o,
  output logic core_sdata_o,
  output logic core_sload_o,
  output logic core_sclr_o
);
  localparam bit InvData = (RST_KIND == RK_SET);

  if (CLK_FALL) begin : g_clk_neg
    assign core_clk_o = ~clk_i;
  end else begin : g_clk_pos
    assign core_clk_o = clk_i;
  end

  if (EN_ACT_LOW) begin : g_en_low
    assign core_ena_o = ~en_i;
  end else begin : g_en_high
    assign core_ena_o = en_i;
  end

  if (RST_KIND == RK_NONE) begin : g_rst_none
    assign core_aclr_no = 1'b1;
  end else if (RST_ACT_LOW) begin : g_rst_low
    assign core_aclr_no = arst_i;
  end else begin : g_rst_high
    assign core_aclr_no = ~arst_i;
  end

  if (InvData) begin : g_inv
    // core clear would read as 1 here, so a clear becomes a load of inverted 0
    assign core_d_o     = ~d_i;
    assign core_sdata_o = sclr_i ? 1'b1 : ~sdata_i;
    assign core_sload_o = sload_i | sclr_i;
    assign core_sclr_o  = 1'b0;
  end else begin : g_pass
    assign core_d_o     = d_i;
    assign core_sdata_o = sdata_i;
    assign core_sload_o = sload_i;
    assign core_sclr_o  = sclr_i;
  end
endmodule

// File: rtl/flop_map_cell.sv
module flop_map_cell
  import flop_map_pkg::*;
#(
  parameter bit        CLK_FALL    = 1'b0,
  parameter rst_kind_e RST_KIND    = RK_CLEAR,
  parameter bit        RST_ACT_LOW = 1'b1,
  parameter bit        EN_ACT_LOW  = 1'b0,
  parameter bit        INIT_VAL    = 1'b0
) (
  input  logic clk_i,
  input  logic arst_i,
  input  logic en_i,
  input  logic d_i,
  input  logic sdata_i,
  input  logic sload_i,
  input  logic sclr_i,
  output logic q_o,
  output logic cfg_err_o
);
  localparam bit InvOut  = (RST_KIND == RK_SET);
  localparam bit PowerUp = InvOut;
  localparam bit CfgErr  = (INIT_VAL != PowerUp);

  logic core_clk, core_aclr_n, core_ena, core_d, core_sdata, core_sload, core_sclr;
  logic core_q;

  flop_pin_adapt #(
    .CLK_FALL   (CLK_FALL),
    .RST_KIND   (RST_KIND),
    .RST_ACT_LOW(RST_ACT_LOW),
    .EN_ACT_LOW (EN_ACT_LOW)
  ) u_adapt (
    .clk_i       (clk_i),
    .arst_i      (arst_i),
    .en_i        (en_i),
    .d_i         (d_i),
    .sdata_i     (sdata_i),
    .sload_i     (sload_i),
    .sclr_i      (sclr_i),
    .core_clk_o  (core_clk),
    .core_aclr_no(core_aclr_n),
    .core_ena_o  (core_ena),
    .core_d_o    (core_d),
    .core_sdata_o(core_sdata),
    .core_sload_o(core_sload),
    .core_sclr_o (core_sclr)
  );

  flop_store_core u_core (
    .clk_i  (core_clk),
    .aclr_ni(core_aclr_n),
    .ena_i  (core_ena),
    .sclr_i (core_sclr),
    .sload_i(core_sload),
    .sdata_i(core_sdata),
    .d_i    (core_d),
    .q_o    (core_q)
  );

  if (InvOut) begin : g_out_inv
    assign q_o = ~core_q;
    AST_SET_ONE: assert property (@(posedge core_clk) disable iff (core_aclr_n)
      1'b1 |-> q_o); // R6
  end else begin : g_out_pass
    assign q_o = core_q;
  end

  assign cfg_err_o = CfgErr;

  AST_SCLR_VISIBLE: assert property (@(posedge core_clk) disable iff (!core_aclr_n)
    (core_ena && sclr_i) |=> !q_o); // R8
endmodule

// File: tb/tb_flop_map_cell.sv
`timescale 1ns/1ps
module tb_flop_map_cell;
  import flop_map_pkg::*;

  localparam int NCfg = 24;

  logic clk = 1'b0;
  always #4 clk = ~clk; // 125 MHz

  // logical stimulus; per-instance pins derive polarity from it
  logic l_rst = 1'b0, l_en = 1'b0, d = 1'b0, sd = 1'b0, sload = 1'b0, sclr = 1'b0;
  logic [NCfg-1:0] q_w, err_w;
  logic [NCfg-1:0] exp_q;
  logic [2:0] bad_err;
  logic [2:0] bad_q;
  int checks = 0, fails = 0;

  for (genvar gi = 0; gi < NCfg; gi++) begin : g_cfg
    localparam bit CF = (gi % 2) == 1;
    localparam bit RL = ((gi / 2) % 2) == 1;
    localparam bit EL = ((gi / 4) % 2) == 1;
    localparam rst_kind_e K = rst_kind_e'(gi / 8);
    localparam bit IV = (gi / 8) == 2;
    logic arst_p, en_p;
    assign arst_p = l_rst ^ RL;
    assign en_p   = l_en ^ EL;
    flop_map_cell #(.CLK_FALL(CF), .RST_KIND(K), .RST_ACT_LOW(RL),
                    .EN_ACT_LOW(EL), .INIT_VAL(IV)) dut (
      .clk_i(clk), .arst_i(arst_p), .en_i(en_p), .d_i(d), .sdata_i(sd),
      .sload_i(sload), .sclr_i(sclr), .q_o(q_w[gi]), .cfg_err_o(err_w[gi]));
  end

  flop_map_cell #(.RST_KIND(RK_CLEAR), .INIT_VAL(1'b1)) bad_clr (
    .clk_i(clk), .arst_i(~l_rst), .en_i(l_en), .d_i(d), .sdata_i(sd),
    .sload_i(sload), .sclr_i(sclr), .q_o(bad_q[0]), .cfg_err_o(bad_err[0]));
  flop_map_cell #(.RST_KIND(RK_SET), .INIT_VAL(1'b0)) bad_set (
    .clk_i(clk), .arst_i(~l_rst), .en_i(l_en), .d_i(d), .sdata_i(sd),
    .sload_i(sload), .sclr_i(sclr), .q_o(bad_q[1]), .cfg_err_o(bad_err[1]));
  flop_map_cell #(.RST_KIND(RK_NONE), .INIT_VAL(1'b1)) bad_none (
    .clk_i(clk), .arst_i(~l_rst), .en_i(l_en), .d_i(d), .sdata_i(sd),
    .sload_i(sload), .sclr_i(sclr), .q_o(bad_q[2]), .cfg_err_o(bad_err[2]));

  task automatic chk(input string req, input logic act, input logic exp, input int idx);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s cfg=%0d actual=%b expected=%b", req, idx, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    for (int i = 0; i < NCfg; i++) chk(req, q_w[i], exp_q[i], i);
  endtask

  // one rising and one falling edge, then sample
  task automatic step();
    @(posedge clk);
    @(negedge clk);
    #1;
  endtask

  task automatic capture_all(input logic v);
    for (int i = 0; i < NCfg; i++) exp_q[i] = v;
  endtask

  task automatic t_powerup(); // R1, R9
    for (int i = 0; i < NCfg; i++) begin
      exp_q[i] = (i / 8) == 2;
      chk("R1", q_w[i], exp_q[i], i);
      chk("R9", err_w[i], 1'b0, i);
    end
    for (int i = 0; i < 3; i++) chk("R9", bad_err[i], 1'b1, 100 + i);
  endtask

  task automatic t_capture(); // R2
    l_en = 1'b1; d = 1'b1; step(); capture_all(1'b1); check_all("R2");
    d = 1'b0; step(); capture_all(1'b0); check_all("R2");
  endtask

  task automatic t_edge_select(); // R2
    d = 1'b1;
    @(posedge clk); #1;
    for (int i = 0; i < NCfg; i++) exp_q[i] = (i % 2) == 0;
    check_all("R2 rise-only");
    @(negedge clk); #1;
    capture_all(1'b1); check_all("R2 fall");
  endtask

  task automatic t_hold(); // R4
    l_en = 1'b0; d = 1'b0; step(); check_all("R4 d");
    sclr = 1'b1; step(); check_all("R4 sclr");
    sclr = 1'b0; sload = 1'b1; sd = 1'b0; step(); check_all("R4 sload");
    sload = 1'b0;
  endtask

  task automatic t_priority(); // R3, R8
    l_en = 1'b1; d = 1'b1; sload = 1'b1; sd = 1'b1; sclr = 1'b1;
    step(); capture_all(1'b0); check_all("R3 R8 clear wins");
    sclr = 1'b0; d = 1'b0; sd = 1'b1;
    step(); capture_all(1'b1); check_all("R3 R8 load sdata");
    d = 1'b1; sd = 1'b0;
    step(); capture_all(1'b0); check_all("R3 R8 load over d");
    sload = 1'b0;
    step(); capture_all(1'b1); check_all("R3 d path");
  endtask

  task automatic t_async(); // R5, R6, R7
    // state is 1 for all; make it 0 so set kind visibly changes
    d = 1'b0; step(); capture_all(1'b0); check_all("R3 d path");
    l_rst = 1'b1; #1;
    for (int i = 0; i < NCfg; i++) if (i / 8 != 0) exp_q[i] = (i / 8) == 2;
    check_all("R5 R6 R7 immediate");
    d = 1'b1; l_en = 1'b1; step();
    for (int i = 0; i < NCfg; i++) if (i / 8 == 0) exp_q[i] = 1'b1;
    check_all("R5 R6 held over capture, R7 none captures");
    d = 1'b0; step();
    for (int i = 0; i < NCfg; i++) if (i / 8 == 0) exp_q[i] = 1'b0;
    check_all("R5 R6 R7 second edge");
    l_rst = 1'b0; #1; check_all("R5 R6 release no change");
    d = 1'b1; step(); capture_all(1'b1); check_all("R2 after release");
    sclr = 1'b1; step(); capture_all(1'b0); check_all("R8 sclr after release");
    sclr = 1'b0;
  endtask

  initial begin
    #1;
    t_powerup();
    t_capture();
    t_edge_select();
    t_hold();
    t_priority();
    t_async();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #100000;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule